// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Compression Logic

This block is the device-side control of a byte-wide dynamic memory whose storage is built internally as two halves of equal size. One external location reaches one byte in each half, so every external data line owns two internal bits. The row strobe, column strobe, write enable and output enable are sampled on a free-running clock. Their sampled edges and the order in which they fall decide what each cycle is: a row access, a refresh of the column-strobe-first kind, or a test-mode entry request.

In normal operation the most significant address bit, taken with the row address, picks the half that is accessed. After a valid entry request the block is in a parallel test mode. A write then places each data bit into both halves at the same location. A read returns, on each line, a 1 where the two internal copies agree and a 0 where they differ. A refresh of the column-first kind, a row-only refresh or a hidden refresh ends the mode. A further entry request while the mode is active counts as a refresh and leaves the mode on.

A small synthesizable array stands in for the real storage. Its size comes from the row and column index widths. Data out is a plain vector with a separate drive-enable flag, which an I/O pad would use to model the high-impedance state.

Top module: `dramtm_top`

## Requirements
- R1: While reset is asserted and after it is released, `test_mode` is 0 and `dout_en` is 0. `dout` is all zeros whenever `dout_en` is 0.
- R2: In normal mode a location is set by the row index (low row bits), the column index (low column bits) and the half bit (address bit 10 at the row-strobe fall). A byte written there reads back unchanged. A write to one half leaves the same location in the other half untouched.
- R3: `dout_en` is 1 only while output enable is low and a column access that began as a read is in progress. A column access that starts with write enable low (early write) never drives the outputs.
- R4: A row-strobe fall that finds the column strobe and write enable already low, with address bits 0 to 9 all high, sets `test_mode`. Address bit 10 does not matter.
- R5: The same sequence with any of address bits 0 to 9 low does not set `test_mode`.
- R6: In test mode a write stores the data byte into the addressed location of both halves, whatever the half bit.
- R7: In test mode a read returns, per bit, 1 where the two halves hold equal bits and 0 where they differ.
- R8: A row-strobe fall with the column strobe already low and write enable high clears `test_mode`.
- R9: A row cycle that ends with no column-strobe fall (row-only refresh) clears `test_mode`.
- R10: A hidden refresh, where the row strobe rises and falls again while the column strobe stays low after a read, clears `test_mode`.
- R11: An entry request made while `test_mode` is 1 keeps it at 1, whatever the address.
- R12: Read data is captured at the column-strobe fall. If write enable falls later in the same column access (read-modify-write), the outputs keep showing the old byte and the new byte is stored.
- R13: Several column-strobe pulses within one row-strobe low period each access their own column (page mode), for both writes and reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 11 | Multiplexed row/column address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, or per-bit agreement flags in test mode |
| dout_en | output | 1 | Drive enable for `dout` (low means high impedance) |
| test_mode | output | 1 | Parallel test mode is active |

## Verification
The hardest case to reach from the pins is a test-mode read that must show disagreement. The array can only hold two different bytes at one location if the halves were written separately in normal mode before the entry request. So the stimulus first writes unequal bytes to the same location in both halves, enters test mode, and expects the XNOR of the two. The hidden refresh is also hard to reach: the column strobe must stay low across a row-strobe rise and the following fall, so a dedicated sequence holds it there while the row strobe toggles.

// File: rtl/dramtm_pkg.sv
package dramtm_pkg;
  // Row-strobe cycle kinds tracked by the strobe decoder
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_ROW   = 2'd1,
    CYC_RFSH  = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/dramtm_strobe_dec.sv
module dramtm_strobe_dec
  import dramtm_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int ENTRY_W  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  output logic                tm_o,
  output logic                half_o,
  output logic [ROW_BITS-1:0] row_o,
  output logic [COL_BITS-1:0] col_o,
  output logic                cap_o,
  output logic                wr_o,
  output logic                col_act_o,
  output logic                early_o
);
  cyc_state_e state_q;
  logic ras_q, cas_q, we_q;
  logic tm_q, half_q, col_seen_q, col_act_q, early_q;
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;

  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic cbr_start, wcbr, entry_ok, col_start;

  assign ras_fall  = ras_q & ~ras_n;
  assign ras_rise  = ~ras_q & ras_n;
  assign cas_fall  = cas_q & ~cas_n;
  assign cas_rise  = ~cas_q & cas_n;
  assign we_fall   = we_q & ~we_n;
  // column strobe low on both the previous and current sample: it led the row strobe
  assign cbr_start = ras_fall & ~cas_q & ~cas_n;
  assign wcbr      = cbr_start & ~we_n;
  assign entry_ok  = &addr[ENTRY_W-1:0];
  assign col_start = (state_q == CYC_ROW) & cas_fall & ~ras_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  // cycle state and row latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CYC_IDLE;
      row_q   <= '0;
      half_q  <= 1'b0;
    end else begin
      case (state_q)
        CYC_IDLE: begin
          if (cbr_start) begin
            state_q <= CYC_RFSH;
          end else if (ras_fall) begin
            state_q <= CYC_ROW;
            row_q   <= addr[ROW_BITS-1:0];
            half_q  <= addr[ADDR_W-1];
          end
        end
        CYC_ROW, CYC_RFSH: begin
          if (ras_rise) state_q <= CYC_IDLE;
        end
        default: state_q <= CYC_IDLE;
      endcase
    end
  end

  // column access tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_seen_q <= 1'b0;
      col_act_q  <= 1'b0;
      early_q    <= 1'b0;
      col_q      <= '0;
    end else begin
      if (ras_fall) col_seen_q <= 1'b0;
      else if (col_start) col_seen_q <= 1'b1;

      if (col_start) begin
        col_act_q <= 1'b1;
        early_q   <= ~we_n;
        col_q     <= addr[COL_BITS-1:0];
      end else if (cas_rise || ras_rise) begin
        col_act_q <= 1'b0;
        early_q   <= 1'b0;
      end
    end
  end

  // test-mode flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q <= 1'b0;
    end else if (cbr_start) begin
      tm_q <= wcbr ? (tm_q | entry_ok) : 1'b0;
    end else if ((state_q == CYC_ROW) && ras_rise && !col_seen_q) begin
      tm_q <= 1'b0;
    end
  end

  assign tm_o      = tm_q;
  assign half_o    = half_q;
  assign row_o     = row_q;
  assign col_o     = col_start ? addr[COL_BITS-1:0] : col_q;
  assign cap_o     = col_start;
  assign wr_o      = (col_start & ~we_n) |
                     (col_act_q & ~early_q & ~cas_n & ~ras_n & we_fall);
  assign col_act_o = col_act_q;
  assign early_o   = early_q;

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> !tm_q);

  a_r4_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n && !cas_q && !cas_n && !we_n && (&addr[ENTRY_W-1:0])) |=> tm_q);

  a_r5_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!tm_q && ras_q && !ras_n && !cas_q && !cas_n && !(&addr[ENTRY_W-1:0])) |=> !tm_q);

  a_r8_cbr_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && !ras_n && !cas_q && !cas_n && we_n) |=> !tm_q);

  a_r11_wcbr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q && ras_q && !ras_n && !cas_q && !cas_n && !we_n) |=> tm_q);
endmodule

// File: rtl/dramtm_array.sv
module dramtm_array #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int DW       = 8,
  parameter int HALVES   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      both,
  input  logic                      half_sel,
  input  logic [ROW_BITS-1:0]       row,
  input  logic [COL_BITS-1:0]       col,
  input  logic [DW-1:0]             wdata,
  output logic [HALVES-1:0][DW-1:0] rdata
);
  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;

  logic [IDX_W-1:0] idx;
  assign idx = {row, col};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (both || (half_sel == 1'(h)))) mem[idx] <= wdata;
    end
    assign rdata[h] = mem[idx];
  end

  a_r6_both_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && both) |=> (g_half[0].mem[$past(idx)] == g_half[1].mem[$past(idx)]));
endmodule

// File: rtl/dramtm_rdpath.sv
module dramtm_rdpath #(
  parameter int DW     = 8,
  parameter int HALVES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap,
  input  logic                      test_mode,
  input  logic                      half_sel,
  input  logic [HALVES-1:0][DW-1:0] rdata,
  input  logic                      col_act,
  input  logic                      early,
  input  logic                      oe_n,
  output logic [DW-1:0]             dout,
  output logic                      dout_en
);
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (cap) begin
      rd_q <= test_mode ? ~(rdata[0] ^ rdata[1]) : rdata[half_sel];
    end
  end

  assign dout_en = col_act & ~early & ~oe_n;
  assign dout    = dout_en ? rd_q : '0;

  a_r12_read_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && $past(dout_en) && !$past(cap)) |-> $stable(dout));
endmodule

// File: rtl/dramtm_top.sv
module dramtm_top #(
  parameter int ADDR_W   = 11,
  parameter int DW       = 8,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int ENTRY_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_en,
  output logic              test_mode
);
  localparam int HALVES = 2;

  logic                      tm, half, cap, wr, col_act, early;
  logic [ROW_BITS-1:0]       row;
  logic [COL_BITS-1:0]       col;
  logic [HALVES-1:0][DW-1:0] rdata;

  dramtm_strobe_dec #(
    .ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .ENTRY_W(ENTRY_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .tm_o(tm), .half_o(half), .row_o(row), .col_o(col),
    .cap_o(cap), .wr_o(wr), .col_act_o(col_act), .early_o(early)
  );

  dramtm_array #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DW), .HALVES(HALVES)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .both(tm), .half_sel(half),
    .row(row), .col(col), .wdata(din), .rdata(rdata)
  );

  dramtm_rdpath #(.DW(DW), .HALVES(HALVES)) u_rd (
    .clk(clk), .rst_n(rst_n), .cap(cap), .test_mode(tm), .half_sel(half),
    .rdata(rdata), .col_act(col_act), .early(early), .oe_n(oe_n),
    .dout(dout), .dout_en(dout_en)
  );

  assign test_mode = tm;

  a_r3_early_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    early |-> !dout_en);
endmodule

// File: tb/dramtm_top_bench.sv
module dramtm_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en, test_mode;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] got;

  always #5 clk = ~clk;

  dramtm_top u_dramtm_top (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .test_mode(test_mode)
  );

  // {half, row[2:0], col[2:0], data[7:0]}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 3'd1, 3'd2, 8'h5A}, {1'b1, 3'd1, 3'd2, 8'hC3},
    {1'b0, 3'd0, 3'd0, 8'h01}, {1'b1, 3'd7, 3'd7, 8'hFE},
    {1'b0, 3'd4, 3'd6, 8'h3C}, {1'b1, 3'd2, 3'd5, 8'h81},
    {1'b0, 3'd6, 3'd1, 8'hF0}, {1'b1, 3'd3, 3'd3, 8'h77}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step2();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [10:0] rowa(input logic h, input logic [2:0] r);
    return {h, 7'd0, r};
  endfunction

  task automatic wr_cyc(input logic h, input logic [2:0] r, input logic [2:0] c,
                        input logic [7:0] d, input logic oe);
    @(negedge clk); addr = rowa(h, r); ras_n = 1'b0; step2();
    addr = {8'd0, c}; we_n = 1'b0; din = d; oe_n = oe; cas_n = 1'b0; step2();
    chk("R3 early write keeps outputs off", {7'd0, dout_en}, 8'd0);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; step2();
  endtask

  task automatic rd_cyc(input logic h, input logic [2:0] r, input logic [2:0] c,
                        output logic [7:0] d);
    @(negedge clk); addr = rowa(h, r); ras_n = 1'b0; step2();
    addr = {8'd0, c}; oe_n = 1'b0; cas_n = 1'b0; step2();
    chk("R3 read drives outputs", {7'd0, dout_en}, 8'd1);
    d = dout;
    cas_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; step2();
  endtask

  task automatic cbr_cyc(input logic we, input logic [10:0] a);
    @(negedge clk); cas_n = 1'b0; we_n = we; step2();
    addr = a; ras_n = 1'b0; step2();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step2();
  endtask

  task automatic ras_only(input logic [2:0] r);
    @(negedge clk); addr = rowa(1'b0, r); ras_n = 1'b0; step2();
    ras_n = 1'b1; step2();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 test_mode in reset", {7'd0, test_mode}, 8'd0);
    chk("R1 dout_en in reset", {7'd0, dout_en}, 8'd0);
    rst_n = 1'b1;
    step2();
    chk("R1 test_mode after reset", {7'd0, test_mode}, 8'd0);
    chk("R1 dout idle", dout, 8'd0);

    // R2: table walk, write then read back each entry
    for (int i = 0; i < 8; i++) begin
      wr_cyc(VEC[i][14], VEC[i][13:11], VEC[i][10:8], VEC[i][7:0], 1'b0);
      rd_cyc(VEC[i][14], VEC[i][13:11], VEC[i][10:8], got);
      chk("R2 readback", got, VEC[i][7:0]);
    end
    rd_cyc(1'b0, 3'd1, 3'd2, got);
    chk("R2 other half untouched", got, 8'h5A);

    // R3: read with output enable high never drives
    @(negedge clk); addr = rowa(1'b0, 3'd0); ras_n = 1'b0; step2();
    addr = 11'd0; cas_n = 1'b0; step2();
    chk("R3 oe high keeps outputs off", {7'd0, dout_en}, 8'd0);
    chk("R1 dout zero when off", dout, 8'd0);
    cas_n = 1'b1; ras_n = 1'b1; step2();

    // R5: entry with a low address bit
    cbr_cyc(1'b0, 11'h3FE);
    chk("R5 no entry with A0 low", {7'd0, test_mode}, 8'd0);
    cbr_cyc(1'b0, 11'h1FF);
    chk("R5 no entry with A9 low", {7'd0, test_mode}, 8'd0);

    // R4: valid entry, A10 set to show it is ignored
    cbr_cyc(1'b0, 11'h7FF);
    chk("R4 entry", {7'd0, test_mode}, 8'd1);

    // R7: halves differ at r1 c2 (5A vs C3)
    rd_cyc(1'b0, 3'd1, 3'd2, got);
    chk("R7 compare mismatch pattern", got, 8'h66);

    // R6: test write then compare
    wr_cyc(1'b1, 3'd2, 3'd5, 8'hA5, 1'b1);
    rd_cyc(1'b0, 3'd2, 3'd5, got);
    chk("R7 compare all equal", got, 8'hFF);

    // R11: entry request in test mode with arbitrary address
    cbr_cyc(1'b0, 11'h000);
    chk("R11 stays in test mode", {7'd0, test_mode}, 8'd1);

    // R8: column-first refresh exits
    cbr_cyc(1'b1, 11'h000);
    chk("R8 exit by refresh", {7'd0, test_mode}, 8'd0);
    rd_cyc(1'b0, 3'd2, 3'd5, got);
    chk("R6 half0 written", got, 8'hA5);
    rd_cyc(1'b1, 3'd2, 3'd5, got);
    chk("R6 half1 written", got, 8'hA5);

    // R9: row-only refresh exits
    cbr_cyc(1'b0, 11'h3FF);
    chk("R4 re-entry", {7'd0, test_mode}, 8'd1);
    ras_only(3'd4);
    chk("R9 exit by row-only refresh", {7'd0, test_mode}, 8'd0);

    // R10: hidden refresh exits
    cbr_cyc(1'b0, 11'h3FF);
    @(negedge clk); addr = rowa(1'b0, 3'd1); ras_n = 1'b0; step2();
    addr = 11'd2; oe_n = 1'b0; cas_n = 1'b0; step2();
    chk("R10 read before hidden refresh", dout, 8'h66);
    ras_n = 1'b1; step2();
    ras_n = 1'b0; step2();
    ras_n = 1'b1; step2();
    cas_n = 1'b1; oe_n = 1'b1; step2();
    chk("R10 exit by hidden refresh", {7'd0, test_mode}, 8'd0);

    // R12: read-modify-write
    wr_cyc(1'b0, 3'd3, 3'd3, 8'h11, 1'b1);
    @(negedge clk); addr = rowa(1'b0, 3'd3); ras_n = 1'b0; step2();
    addr = 11'd3; oe_n = 1'b0; cas_n = 1'b0; step2();
    chk("R12 old data", dout, 8'h11);
    din = 8'h22; we_n = 1'b0; step2();
    chk("R12 old data held after write", dout, 8'h11);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; step2();
    rd_cyc(1'b0, 3'd3, 3'd3, got);
    chk("R12 new data stored", got, 8'h22);
    rd_cyc(1'b1, 3'd3, 3'd3, got);
    chk("R12 other half kept", got, 8'h77);

    // R13: page-mode writes and reads in row 5
    @(negedge clk); addr = rowa(1'b0, 3'd5); ras_n = 1'b0; step2();
    for (int c = 0; c < 3; c++) begin
      addr = 11'(c); din = 8'(8'h30 + c); we_n = 1'b0; cas_n = 1'b0; step2();
      cas_n = 1'b1; we_n = 1'b1; step2();
    end
    ras_n = 1'b1; step2();
    @(negedge clk); addr = rowa(1'b0, 3'd5); ras_n = 1'b0; step2();
    for (int c = 2; c >= 0; c--) begin
      addr = 11'(c); oe_n = 1'b0; cas_n = 1'b0; step2();
      chk("R13 page read", dout, 8'(8'h30 + c));
      cas_n = 1'b1; oe_n = 1'b1; step2();
    end
    ras_n = 1'b1; step2();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule